// File: doc/BRIEF.md
# Wide Floating-Point Adder with Chunked Carry Pipeline

This block adds two floating-point operands in a very wide format. Each word holds a sign bit at the top, a 63-bit unsigned exponent below it, and a mantissa in all remaining bits. The mantissa carries its leading one explicitly, so a nonzero operand is normalised when the mantissa MSB is set. Zero is the all-zeros word. The total width `W` is a parameter and is meant to be a multiple of 512, so that one word lines up with a wide memory beat.

The adder orders the two operands by magnitude and shifts the smaller one right to align it. It then adds or subtracts the mantissas and renormalises the result. A mantissa add several hundred bits wide cannot close timing as one carry chain. The add is therefore cut into pieces `BASE_W` bits wide, each in its own pipeline stage, with the carry registered from one piece to the next. When the mantissa fits in one piece, a single native add is used. One operation is accepted on every clock, and a valid flag travels with each operation. NaN, infinity and subnormal encodings are not supported. Dropped bits are truncated. The caller keeps exponents below the top value, so a carry cannot overflow the exponent.

Top module: `wide_fp_adder`

## Requirements
- R1: Word layout: bit W-1 is the sign, bits W-2 down to W-64 are the exponent, and the low MAN_W = W-64 bits are the mantissa. A nonzero result always has mantissa bit MAN_W-1 set. A zero result is emitted as all zeros.
- R2: When both signs match, the result mantissa is the truncated sum of the aligned mantissas. The result takes that common sign and the larger exponent, adjusted only by normalisation.
- R3: The operand of smaller magnitude (compared as exponent, then mantissa) is shifted right by the exponent difference, and the bits shifted out are dropped. A difference of MAN_W or more makes it contribute nothing, so the result equals the larger operand.
- R4: When the signs differ, the smaller magnitude is subtracted from the larger and the result carries the sign of the larger. Equal magnitudes give all zeros.
- R5: A carry out of the mantissa add shifts the mantissa right by one, inserts a one at the top and raises the exponent by one. Otherwise the mantissa is shifted left by its leading-zero count and the exponent is lowered by that count.
- R6: A new operation is accepted every cycle. out_valid is high exactly NCH+3 rising edges after the edge that samples in_valid, where NCH = ceil(MAN_W/BASE_W). Back-to-back inputs give back-to-back outputs in order. With BASE_W >= MAN_W the mantissa add is a single stage.
- R7: A zero operand returns the other operand. A result whose leading-zero count exceeds the larger exponent is flushed to all zeros.
- R8: A synchronous active-high rst clears every valid flag in the pipeline. out_valid is low on the cycle after rst, and operations in flight at reset never appear.
- R9: Carries and borrows pass correctly through every chunk boundary. Examples are an all-ones mantissa plus one unit in the last place, and a power of two minus one unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | W | First operand |
| in_b | input | W | Second operand |
| out_valid | output | 1 | Result present this cycle |
| out_sum | output | W | Registered sum |

## Verification
Two functions can meet in the same cycle: a carry or borrow rippling through every chunk stage, and a following operation entering the first chunk stage behind it. If the registered carry were shared between stages or badly aligned, one operation would corrupt the next. The bench feeds its whole vector table back to back, with full-width carry and borrow cases placed among the other vectors, and compares each result in arrival order with an independent wide-integer model. A second instance with a one-stage mantissa add receives the same stream, and both must agree with the model.

// File: rtl/wfa_pkg.sv
package wfa_pkg;
  // exponent field width is fixed by the word format
  localparam int EXP_W = 63;

  // sideband that travels with each operation through the add pipeline
  typedef struct packed {
    logic             sign;   // sign of the larger-magnitude operand
    logic             sub;    // effective subtraction
    logic [EXP_W-1:0] exp;    // exponent of the larger-magnitude operand
  } side_t;
endpackage

// File: rtl/wfa_align.sv
module wfa_align
  import wfa_pkg::*;
#(
  parameter int W     = 512,
  parameter int PAD_W = 448
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  output logic             out_valid,
  output logic [PAD_W-1:0] out_a,
  output logic [PAD_W-1:0] out_b,
  output logic             out_cin,
  output side_t            out_side
);
  localparam int MAN_W = W - 1 - EXP_W;
  localparam int SHW   = $clog2(MAN_W);

  logic             sa, sb;
  logic [EXP_W-1:0] ea, eb;
  logic [MAN_W-1:0] ma, mb;
  logic             a_big;

  assign {sa, ea, ma} = in_a;
  assign {sb, eb, mb} = in_b;
  // magnitude order: exponent first, mantissa breaks ties
  assign a_big = ({ea, ma} >= {eb, mb});

  // stage 1: order operands by magnitude
  logic             v1;
  logic [MAN_W-1:0] big_m, sml_m;
  logic [EXP_W-1:0] big_e, sml_e;
  logic             sgn1, sub1;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
    big_m <= a_big ? ma : mb;
    sml_m <= a_big ? mb : ma;
    big_e <= a_big ? ea : eb;
    sml_e <= a_big ? eb : ea;
    sgn1  <= a_big ? sa : sb;
    sub1  <= sa ^ sb;
  end

  // stage 2: align the smaller operand and prepare the two's complement
  logic [EXP_W-1:0] diff;
  logic             far;
  logic [MAN_W-1:0] shifted, b_op;

  assign diff    = big_e - sml_e;
  assign far     = (diff >= EXP_W'(MAN_W));
  assign shifted = far ? '0 : (sml_m >> diff[SHW-1:0]);
  assign b_op    = sub1 ? ~shifted : shifted;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v1;
    out_a    <= PAD_W'(big_m);
    out_b    <= PAD_W'(b_op);
    out_cin  <= sub1;
    out_side <= '{sign: sgn1, sub: sub1, exp: big_e};
  end

  // the selected larger operand never has smaller magnitude than the other
  p_swap_order_r4 : assert property (@(posedge clk) disable iff (rst)
    v1 |-> ({big_e, big_m} >= {sml_e, sml_m}));
endmodule

// File: rtl/wfa_chunk_add.sv
module wfa_chunk_add
  import wfa_pkg::*;
#(
  parameter int PAD_W  = 448,
  parameter int BASE_W = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [PAD_W-1:0] in_a,
  input  logic [PAD_W-1:0] in_b,
  input  logic           in_cin,
  input  side_t          in_side,
  output logic           out_valid,
  output logic [PAD_W:0] out_sum,
  output side_t          out_side
);
  localparam int NCH = PAD_W / BASE_W;
  localparam int CW1 = BASE_W + 1;

  for (genvar k = 0; k < NCH; k++) begin : gen_st
    logic [PAD_W-1:0] a_i, b_i, s_i;
    logic             c_i, v_i, ci0_i;
    side_t            sd_i;
    logic [PAD_W-1:0] a_q, b_q, s_q;
    logic             c_q, v_q, ci0_q;
    side_t            sd_q;
    logic [BASE_W:0]  part;

    if (k == 0) begin : g_head
      assign a_i   = in_a;
      assign b_i   = in_b;
      assign s_i   = '0;
      assign c_i   = in_cin;
      assign ci0_i = in_cin;
      assign v_i   = in_valid;
      assign sd_i  = in_side;
    end else begin : g_tail
      assign a_i   = gen_st[k-1].a_q;
      assign b_i   = gen_st[k-1].b_q;
      assign s_i   = gen_st[k-1].s_q;
      assign c_i   = gen_st[k-1].c_q;
      assign ci0_i = gen_st[k-1].ci0_q;
      assign v_i   = gen_st[k-1].v_q;
      assign sd_i  = gen_st[k-1].sd_q;
    end

    // one native add per stage: this chunk plus the registered carry
    assign part = {1'b0, a_i[k*BASE_W +: BASE_W]}
                + {1'b0, b_i[k*BASE_W +: BASE_W]}
                + CW1'(c_i);

    always_ff @(posedge clk) begin
      if (rst) v_q <= 1'b0;
      else     v_q <= v_i;
      a_q   <= a_i;
      b_q   <= b_i;
      s_q   <= s_i;
      s_q[k*BASE_W +: BASE_W] <= part[BASE_W-1:0];
      c_q   <= part[BASE_W];
      ci0_q <= ci0_i;
      sd_q  <= sd_i;
    end
  end

  assign out_valid = gen_st[NCH-1].v_q;
  assign out_sum   = {gen_st[NCH-1].c_q, gen_st[NCH-1].s_q};
  assign out_side  = gen_st[NCH-1].sd_q;

  // the chunked ripple must equal one full-width add of the same operands
  p_chain_sum_r9 : assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sum == ({1'b0, gen_st[NCH-1].a_q}
                             + {1'b0, gen_st[NCH-1].b_q}
                             + (PAD_W+1)'(gen_st[NCH-1].ci0_q))));
endmodule

// File: rtl/wfa_normalize.sv
module wfa_normalize
  import wfa_pkg::*;
#(
  parameter int W     = 512,
  parameter int PAD_W = 448
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [PAD_W:0] in_sum,
  input  side_t          in_side,
  output logic           out_valid,
  output logic [W-1:0]   out_word
);
  localparam int MAN_W = W - 1 - EXP_W;
  localparam int CW    = $clog2(MAN_W + 1);

  function automatic logic [CW-1:0] lead_zeros(input logic [MAN_W-1:0] v);
    logic [CW-1:0] n;
    n = CW'(MAN_W);
    for (int i = 0; i < MAN_W; i++)
      if (v[i]) n = CW'(MAN_W - 1 - i);
    return n;
  endfunction

  // stage 1: carry handling and leading-zero count
  logic [MAN_W-1:0] mant;
  logic             cy;
  logic [CW-1:0]    lz;

  assign mant = in_sum[MAN_W-1:0];
  // padding bits above the mantissa only ever hold the carry out
  assign cy   = (|in_sum[PAD_W:MAN_W]) & ~in_side.sub;
  assign lz   = lead_zeros(mant);

  logic             v1, s1, zero1;
  logic [MAN_W-1:0] m1;
  logic [CW-1:0]    lz1;
  logic [EXP_W-1:0] e1;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
    m1    <= cy ? {1'b1, mant[MAN_W-1:1]} : mant;
    lz1   <= cy ? '0 : lz;
    e1    <= cy ? in_side.exp + 1'b1 : in_side.exp;
    zero1 <= ~cy & (mant == '0);
    s1    <= in_side.sign;
  end

  // stage 2: left shift, exponent adjust, zero and underflow flush
  logic             kill;
  logic [MAN_W-1:0] norm;
  logic [EXP_W-1:0] new_e;

  assign kill  = zero1 | (EXP_W'(lz1) > e1);
  assign norm  = m1 << lz1;
  assign new_e = e1 - EXP_W'(lz1);

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v1;
    out_word <= kill ? '0 : {s1, new_e, norm};
  end

  p_norm_msb_r5 : assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_word != '0)) |-> out_word[MAN_W-1]);

  p_zero_pack_r7 : assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_word[MAN_W-1:0] == '0)) |-> (out_word == '0));
endmodule

// File: rtl/wide_fp_adder.sv
module wide_fp_adder
  import wfa_pkg::*;
#(
  parameter int W      = 512,
  parameter int BASE_W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_sum
);
  localparam int MAN_W = W - 1 - EXP_W;
  localparam int NCH   = (MAN_W + BASE_W - 1) / BASE_W;
  localparam int PAD_W = NCH * BASE_W;

  logic             al_valid, al_cin;
  logic [PAD_W-1:0] al_a, al_b;
  side_t            al_side;

  logic             ad_valid;
  logic [PAD_W:0]   ad_sum;
  side_t            ad_side;

  wfa_align #(.W(W), .PAD_W(PAD_W)) u_align (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (al_valid),
    .out_a     (al_a),
    .out_b     (al_b),
    .out_cin   (al_cin),
    .out_side  (al_side)
  );

  wfa_chunk_add #(.PAD_W(PAD_W), .BASE_W(BASE_W)) u_add (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (al_valid),
    .in_a      (al_a),
    .in_b      (al_b),
    .in_cin    (al_cin),
    .in_side   (al_side),
    .out_valid (ad_valid),
    .out_sum   (ad_sum),
    .out_side  (ad_side)
  );

  wfa_normalize #(.W(W), .PAD_W(PAD_W)) u_norm (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (ad_valid),
    .in_sum    (ad_sum),
    .in_side   (ad_side),
    .out_valid (out_valid),
    .out_word  (out_sum)
  );

  p_flush_r8 : assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: tb/wide_fp_adder_tb.sv
module wide_fp_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W      = 512;
  localparam int BASE_W = 64;
  localparam int EXP_W  = 63;
  localparam int MAN_W  = W - 1 - EXP_W;
  localparam int NCH    = (MAN_W + BASE_W - 1) / BASE_W;
  localparam int LAT    = NCH + 3;
  localparam int LAT1   = 1 + 3;          // single-stage instance
  localparam int NV     = 15;

  typedef struct packed {
    logic sa; logic fa; logic [15:0] ea; logic [63:0] ha; logic [63:0] la;
    logic sb; logic fb; logic [15:0] eb; logic [63:0] hb; logic [63:0] lb;
  } vec_t;

  localparam logic [63:0] H8 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] HF = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,16'd100, H8, 64'd0,  1'b0,1'b0,16'd100, H8, 64'd0},
    '{1'b0,1'b0,16'd100, 64'hC000_0000_0000_0000, 64'd0,
      1'b0,1'b0,16'd97,  64'hA000_0000_0000_0000, 64'd0},
    '{1'b0,1'b0,16'd100, 64'h8000_0000_0000_0001, 64'd0, 1'b1,1'b0,16'd100, H8, 64'd0},
    '{1'b0,1'b0,16'd200, 64'h9234_5678_9ABC_DEF0, 64'h1234,
      1'b1,1'b0,16'd200, 64'h9234_5678_9ABC_DEF0, 64'h1234},
    '{1'b1,1'b0,16'd1000, H8, 64'd5, 1'b0,1'b0,16'd100, HF, HF},
    '{1'b0,1'b0,16'd547, H8, 64'd0,  1'b0,1'b0,16'd100, H8, 64'd0},
    '{1'b0,1'b0,16'd0, 64'd0, 64'd0, 1'b1,1'b0,16'd300, 64'h8765_4321_0FED_CBA9, 64'h42},
    '{1'b0,1'b1,16'd600, HF, HF,     1'b0,1'b0,16'd153, H8, 64'd0},
    '{1'b0,1'b0,16'd600, H8, 64'd0,  1'b1,1'b0,16'd153, H8, 64'd0},
    '{1'b0,1'b0,16'd2,   H8, 64'd1,  1'b1,1'b0,16'd2,   H8, 64'd0},
    '{1'b1,1'b0,16'd50,  64'hC000_0000_0000_0000, 64'd3, 1'b1,1'b0,16'd48, H8, 64'd7},
    '{1'b0,1'b0,16'd40,  H8, 64'd0,  1'b1,1'b0,16'd41,  H8, 64'd0},
    '{1'b0,1'b0,16'd100, H8, 64'd0,  1'b0,1'b0,16'd96,  H8, 64'hF},
    '{1'b1,1'b0,16'd70,  H8, 64'd0,  1'b0,1'b0,16'd69,  HF, HF},
    '{1'b0,1'b0,16'd548, H8, 64'd0,  1'b0,1'b0,16'd100, H8, 64'd0}
  };

  string tags [NV] = '{"R2","R3","R5","R4","R3","R3","R7","R9","R9","R7","R2","R4","R3","R5","R3"};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         out_valid, out_valid1;
  logic [W-1:0] out_sum, out_sum1;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] va [NV];
  logic [W-1:0] vb [NV];
  logic [W-1:0] ve [NV];

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_fp_adder #(.W(W), .BASE_W(BASE_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_sum(out_sum));

  // mantissa fits in one chunk: single native add stage
  wide_fp_adder #(.W(W), .BASE_W(512)) u_dut_single (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid1), .out_sum(out_sum1));

  function automatic logic [W-1:0] mk(input logic s, input logic f,
      input logic [15:0] e, input logic [63:0] hi, input logic [63:0] lo);
    logic [MAN_W-1:0] m;
    m = f ? '1 : '0;
    m[MAN_W-1 -: 64] = hi;
    m[63:0] = lo;
    return {s, EXP_W'(e), m};
  endfunction

  // reference: exact wide-integer arithmetic from the requirements
  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    logic sa, sb, sg;
    logic [EXP_W-1:0] ea, eb, eg, el, d;
    logic [MAN_W-1:0] ma, mb, mg, ml, sh, mres;
    logic [MAN_W:0] s;
    int lz;
    {sa, ea, ma} = a;
    {sb, eb, mb} = b;
    if ({ea, ma} >= {eb, mb}) begin sg = sa; eg = ea; mg = ma; el = eb; ml = mb; end
    else                      begin sg = sb; eg = eb; mg = mb; el = ea; ml = ma; end
    d  = eg - el;
    sh = (d >= EXP_W'(MAN_W)) ? '0 : (ml >> d);
    if (sa == sb) s = {1'b0, mg} + {1'b0, sh};
    else          s = {1'b0, mg} - {1'b0, sh};
    if (s[MAN_W]) return {sg, eg + 1'b1, s[MAN_W:1]};
    if (s == '0) return '0;
    lz = 0;
    while (!s[MAN_W-1-lz]) lz++;
    if (eg < EXP_W'(lz)) return '0;
    mres = s[MAN_W-1:0] << lz;
    return {sg, eg - EXP_W'(lz), mres};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int i0, i1, first0, last0;
    int c0, c1, seen;
    for (int i = 0; i < NV; i++) begin
      va[i] = mk(VECS[i].sa, VECS[i].fa, VECS[i].ea, VECS[i].ha, VECS[i].la);
      vb[i] = mk(VECS[i].sb, VECS[i].fb, VECS[i].eb, VECS[i].hb, VECS[i].lb);
      ve[i] = model(va[i], vb[i]);
    end

    // R8: valid held high during reset never reaches the output
    in_valid = 1'b1;
    repeat (LAT + 3) @(negedge clk);
    check_int("R8 reset out_valid", int'(out_valid), 0);
    check_int("R8 reset out_valid single", int'(out_valid1), 0);
    in_valid = 1'b0;
    rst = 1'b0;
    repeat (LAT + 3) @(negedge clk);

    // table walk, back to back; R6 ordering and throughput
    i0 = 0; i1 = 0; first0 = -1; last0 = -1;
    for (int cyc = 0; cyc < NV + LAT + 4; cyc++) begin
      @(negedge clk);
      if (out_valid) begin
        if (i0 < NV) check(tags[i0], out_sum, ve[i0]);
        if (first0 < 0) first0 = cyc;
        last0 = cyc;
        i0++;
      end
      if (out_valid1) begin
        if (i1 < NV) check({tags[i1], " single"}, out_sum1, ve[i1]);
        i1++;
      end
      if (cyc < NV) begin
        in_valid = 1'b1; in_a = va[cyc]; in_b = vb[cyc];
      end else begin
        in_valid = 1'b0;
      end
    end
    check_int("R6 result count", i0, NV);
    check_int("R6 result count single", i1, NV);
    check_int("R6 back-to-back span", last0 - first0, NV - 1);

    // R6: latency of a lone operation, both instances
    @(negedge clk);
    in_valid = 1'b1; in_a = va[7]; in_b = vb[7];
    @(negedge clk);
    in_valid = 1'b0;
    c0 = -1; c1 = -1;
    for (int k = 0; k < LAT + 5; k++) begin
      if (out_valid && c0 < 0) begin c0 = k; check("R9 lone carry", out_sum, ve[7]); end
      if (out_valid1 && c1 < 0) begin c1 = k; check("R9 lone carry single", out_sum1, ve[7]); end
      @(negedge clk);
    end
    check_int("R6 latency", c0, LAT);
    check_int("R6 latency single", c1, LAT1);

    // R1: zero-plus-zero emits all zeros
    in_valid = 1'b1; in_a = '0; in_b = '0;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < LAT + 3; k++) begin
      if (out_valid) check("R1 zero word", out_sum, '0);
      @(negedge clk);
    end

    // R8: reset while operations are in flight discards them
    in_valid = 1'b1; in_a = va[0]; in_b = vb[0];
    @(negedge clk);
    in_a = va[1]; in_b = vb[1];
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    seen = 0;
    for (int k = 0; k < LAT + 4; k++) begin
      if (out_valid || out_valid1) seen++;
      @(negedge clk);
    end
    check_int("R8 flushed in flight", seen, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule